// File: doc/BRIEF.md
# Parallel Camera Pixel Capture Front-End

This block sits between a parallel 8-bit image sensor and the pixel FIFO of an imaging pipeline. It samples the sensor's pixel clock, vertical sync, horizontal sync and data bus with a fast system clock, which must run at least four times the pixel clock. From the sampled pixel-clock waveform it finds the edge chosen for capture, rising or falling. For each qualified edge it emits the byte with a one-cycle valid strobe. When vertical sync enters its active level, it also emits a one-cycle start-of-frame pulse. Downstream logic uses that pulse to flush its FIFOs and restart its statistics.

Pixel qualification has two run-time modes. In line-gated mode, horizontal sync is ANDed with the detected clock edge: only edges inside an active line produce a byte, whatever vertical sync does. In free-running mode, horizontal sync plays no part in qualification: every selected edge produces a byte while vertical sync is at its active level. The active level of vertical sync is set by a polarity input.

A debug counter reports how many bytes were captured in the most recent complete line, counted from the rise to the fall of horizontal sync.

Top module: `cam_capture_top`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `pix_valid`, `sof_pulse`, `pix_data` and `line_pix_count` are all zero.
- R2: When `cfg_fall_edge` is 0, a byte is captured at each low-to-high transition of `pclk_in`. When it is 1, a byte is captured at each high-to-low transition. The captured byte is the value of `data_in` at the first sample showing the new level.
- R3: With `cfg_gated` = 1, a byte is captured only if `hsync_in` (active high) is high at the sample where the edge is detected. Vertical sync has no effect on capture in this mode.
- R4: With `cfg_gated` = 0, `hsync_in` has no effect on capture. A byte is captured only if `vsync_in` equals `cfg_vs_pol` at the edge sample (1 = active high, 0 = active low).
- R5: Every captured byte appears on `pix_data`, with `pix_valid` high for exactly one cycle, two clock cycles after the edge is present on the input pins. `pix_data` holds its value between strobes.
- R6: `sof_pulse` is high for exactly one cycle, two clock cycles after `vsync_in` changes to the level given by `cfg_vs_pol`. It pulses once per frame in both modes.
- R7: Levels of `pclk_in` or `vsync_in` already present when reset is released produce no byte and no start-of-frame pulse. Only later transitions count.
- R8: `line_pix_count` shows the number of bytes captured between a rise and the following fall of `hsync_in`. It is updated at the fall and saturates at 2^CNT_W-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock, at least 4x pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_gated | input | 1 | 1 = line-gated qualification, 0 = frame-only qualification |
| cfg_fall_edge | input | 1 | 1 = capture on falling pixel-clock edge, 0 = rising |
| cfg_vs_pol | input | 1 | Active level of vertical sync |
| pclk_in | input | 1 | Sensor pixel clock, treated as data |
| vsync_in | input | 1 | Sensor vertical sync |
| hsync_in | input | 1 | Sensor horizontal sync, active high |
| data_in | input | 8 | Sensor pixel data |
| pix_valid | output | 1 | One-cycle strobe per captured byte |
| pix_data | output | 8 | Captured byte |
| sof_pulse | output | 1 | One-cycle start-of-frame pulse |
| line_pix_count | output | CNT_W | Bytes captured in the last complete line |

## Verification
The bench sweeps all eight combinations of gating mode, capture edge and vertical-sync polarity. In each one it compares the full captured byte sequence against a list derived from the requirements. Line tails with horizontal sync low are included, so a design that ignored the gate in line-gated mode, or honoured it in free-running mode, would produce extra or missing bytes. Each run starts with the pixel clock and vertical sync already at their active levels during reset; a design without a priming guard would report a phantom byte or frame pulse there. Lines longer than the counter's range are driven with a small counter width, so a counter that wraps instead of saturating would read back a small value.

// File: rtl/cap_pkg.sv
package cap_pkg;
  localparam int PIX_W = 8;

  typedef struct packed {
    logic             pclk;
    logic             vs;
    logic             hs;
    logic [PIX_W-1:0] data;
  } sens_t;
endpackage

// File: rtl/cap_sampler.sv
module cap_sampler
  import cap_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  sens_t raw,
  output sens_t cur,
  output sens_t prev,
  output logic  primed
);
  localparam int PRIME_N = 2;
  localparam int PC_W    = $clog2(PRIME_N + 1);

  logic [PC_W-1:0] prime_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cur       <= '0;
      prev      <= '0;
      prime_cnt <= '0;
    end else begin
      cur  <= raw;
      prev <= cur;
      if (prime_cnt != PC_W'(PRIME_N))
        prime_cnt <= prime_cnt + 1'b1;
    end
  end

  assign primed = (prime_cnt == PC_W'(PRIME_N));
endmodule

// File: rtl/cap_edge_sel.sv
module cap_edge_sel (
  input  logic pclk_cur,
  input  logic pclk_prev,
  input  logic primed,
  input  logic fall_sel,
  output logic edge_hit
);
  logic rise_w, fall_w;

  always_comb begin
    rise_w   = pclk_cur & ~pclk_prev;
    fall_w   = ~pclk_cur & pclk_prev;
    edge_hit = primed & (fall_sel ? fall_w : rise_w);
  end
endmodule

// File: rtl/cap_sof_gen.sv
module cap_sof_gen (
  input  logic clk,
  input  logic rst,
  input  logic vs_cur,
  input  logic vs_prev,
  input  logic vs_pol,
  input  logic primed,
  output logic frame_act,
  output logic sof
);
  logic act_cur, act_prev;

  always_comb begin
    act_cur   = ~(vs_cur ^ vs_pol);
    act_prev  = ~(vs_prev ^ vs_pol);
    frame_act = act_cur;
  end

  always_ff @(posedge clk) begin
    if (rst) sof <= 1'b0;
    else     sof <= primed & act_cur & ~act_prev;
  end
endmodule

// File: rtl/cap_line_cnt.sv
module cap_line_cnt #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hs_cur,
  input  logic             hs_prev,
  input  logic             primed,
  input  logic             inc,
  output logic [CNT_W-1:0] last_count
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] run_cnt, run_next;
  logic             hs_rise, hs_fall;

  always_comb begin
    hs_rise  = primed & hs_cur & ~hs_prev;
    hs_fall  = primed & ~hs_cur & hs_prev;
    run_next = run_cnt;
    if (inc && run_cnt != CNT_MAX)
      run_next = run_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_cnt    <= '0;
      last_count <= '0;
    end else begin
      if (hs_rise)
        run_cnt <= inc ? CNT_W'(1) : '0;
      else
        run_cnt <= run_next;
      if (hs_fall)
        last_count <= run_next;
    end
  end
endmodule

// File: rtl/cam_capture_top.sv
module cam_capture_top
  import cap_pkg::*;
#(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_gated,
  input  logic             cfg_fall_edge,
  input  logic             cfg_vs_pol,
  input  logic             pclk_in,
  input  logic             vsync_in,
  input  logic             hsync_in,
  input  logic [PIX_W-1:0] data_in,
  output logic             pix_valid,
  output logic [PIX_W-1:0] pix_data,
  output logic             sof_pulse,
  output logic [CNT_W-1:0] line_pix_count
);
  sens_t raw_s, cur_s, prev_s;
  logic  primed, edge_hit, frame_act, take;

  always_comb begin
    raw_s.pclk = pclk_in;
    raw_s.vs   = vsync_in;
    raw_s.hs   = hsync_in;
    raw_s.data = data_in;
  end

  cap_sampler u_smp (
    .clk(clk), .rst(rst), .raw(raw_s), .cur(cur_s), .prev(prev_s), .primed(primed)
  );

  cap_edge_sel u_edge (
    .pclk_cur(cur_s.pclk), .pclk_prev(prev_s.pclk), .primed(primed),
    .fall_sel(cfg_fall_edge), .edge_hit(edge_hit)
  );

  cap_sof_gen u_sof (
    .clk(clk), .rst(rst), .vs_cur(cur_s.vs), .vs_prev(prev_s.vs),
    .vs_pol(cfg_vs_pol), .primed(primed), .frame_act(frame_act), .sof(sof_pulse)
  );

  always_comb take = edge_hit & (cfg_gated ? cur_s.hs : frame_act);

  cap_line_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .hs_cur(cur_s.hs), .hs_prev(prev_s.hs),
    .primed(primed), .inc(take), .last_count(line_pix_count)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_valid <= 1'b0;
      pix_data  <= '0;
    end else begin
      pix_valid <= take;
      if (take) pix_data <= cur_s.data;
    end
  end
endmodule

// File: rtl/cam_capture_chk.sv
module cam_capture_chk (
  input logic clk,
  input logic rst,
  input logic cfg_gated,
  input logic cfg_fall_edge,
  input logic cfg_vs_pol,
  input logic pclk_in,
  input logic vsync_in,
  input logic hsync_in,
  input logic pix_valid,
  input logic sof_pulse
);
  // R5: strobe lasts one cycle
  p_valid_single_r5: assert property (@(posedge clk) disable iff (rst)
    pix_valid |=> !pix_valid);

  // R6: frame pulse lasts one cycle
  p_sof_single_r6: assert property (@(posedge clk) disable iff (rst)
    sof_pulse |=> !sof_pulse);

  // R6: pulse follows an entry into the active vertical level
  p_sof_cause_r6: assert property (@(posedge clk) disable iff (rst)
    sof_pulse |-> ($past(vsync_in, 2) == cfg_vs_pol) && ($past(vsync_in, 3) != cfg_vs_pol));

  // R2: rising-edge capture needs a low-to-high pin transition
  p_rise_cause_r2: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && !cfg_fall_edge) |-> $past(pclk_in, 2) && !$past(pclk_in, 3));

  // R2: falling-edge capture needs a high-to-low pin transition
  p_fall_cause_r2: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && cfg_fall_edge) |-> !$past(pclk_in, 2) && $past(pclk_in, 3));

  // R3: gated capture only inside an active line
  p_gate_hs_r3: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && cfg_gated) |-> $past(hsync_in, 2));

  // R4: free-running capture only inside an active frame
  p_frame_vs_r4: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && !cfg_gated) |-> ($past(vsync_in, 2) == cfg_vs_pol));
endmodule

bind cam_capture_top cam_capture_chk i_chk (
  .clk(clk), .rst(rst), .cfg_gated(cfg_gated), .cfg_fall_edge(cfg_fall_edge),
  .cfg_vs_pol(cfg_vs_pol), .pclk_in(pclk_in), .vsync_in(vsync_in),
  .hsync_in(hsync_in), .pix_valid(pix_valid), .sof_pulse(sof_pulse)
);

// File: tb/test_cam_capture_top.sv
module test_cam_capture_top;
  localparam int CW   = 4;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_gated = 1'b0, cfg_fall_edge = 1'b0, cfg_vs_pol = 1'b1;
  logic          pclk_in = 1'b0, vsync_in = 1'b0, hsync_in = 1'b0;
  logic [7:0]    data_in = '0;
  logic          pix_valid, sof_pulse;
  logic [7:0]    pix_data;
  logic [CW-1:0] line_pix_count;

  int errors = 0, checks = 0, cycles = 0, sof_seen = 0;
  bit done = 0;
  logic [7:0] got_q[$];
  logic [7:0] exp_q[$];

  always #4 clk = ~clk;

  cam_capture_top #(.CNT_W(CW)) i_cam_capture_top (
    .clk(clk), .rst(rst), .cfg_gated(cfg_gated), .cfg_fall_edge(cfg_fall_edge),
    .cfg_vs_pol(cfg_vs_pol), .pclk_in(pclk_in), .vsync_in(vsync_in),
    .hsync_in(hsync_in), .data_in(data_in), .pix_valid(pix_valid),
    .pix_data(pix_data), .sof_pulse(sof_pulse), .line_pix_count(line_pix_count)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (pix_valid) got_q.push_back(pix_data);
      if (sof_pulse) sof_seen++;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=0", cycles);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // one pixel: inactive phase (data changes here), then active phase
  task automatic px(input logic [7:0] d, input logic hs, input logic vact);
    @(negedge clk);
    data_in  = d;
    hsync_in = hs;
    vsync_in = vact ? cfg_vs_pol : ~cfg_vs_pol;
    pclk_in  = cfg_fall_edge;
    @(negedge clk);
    @(negedge clk);
    pclk_in  = ~cfg_fall_edge;
    @(negedge clk);
    if (cfg_gated ? hs : vact) exp_q.push_back(d);
  endtask

  task automatic run_cfg(input int g, input int f, input int p);
    int sof_exp = 0;
    cfg_gated = g[0]; cfg_fall_edge = f[0]; cfg_vs_pol = p[0];
    rst = 1'b1;
    // active levels present during reset (R7)
    pclk_in = ~f[0]; vsync_in = p[0]; hsync_in = 1'b1; data_in = 8'hA5;
    repeat (4) @(negedge clk);
    check("R1 valid", pix_valid, 0);
    check("R1 sof", sof_pulse, 0);
    check("R1 data", pix_data, 0);
    check("R1 count", line_pix_count, 0);
    rst = 1'b0;
    got_q.delete(); exp_q.delete(); sof_seen = 0;
    @(negedge clk);
    check("R1 valid after", pix_valid, 0);
    repeat (6) @(negedge clk);
    check("R7 no phantom byte", got_q.size(), 0);
    check("R7 no phantom sof", sof_seen, 0);
    // leave the frame, idle pixels outside the frame
    px(8'h11, 1'b0, 1'b0);
    px(8'h12, 1'b0, 1'b0);
    for (int fr = 0; fr < 2; fr++) begin
      sof_exp++;
      for (int ln = 0; ln < 3; ln++) begin
        int len = 3 + ln * 7 + fr;
        px(8'(fr * 90 + ln * 29 + 1), 1'b0, 1'b1);
        px(8'(fr * 90 + ln * 29 + 2), 1'b0, 1'b1);
        for (int i = 0; i < len; i++)
          px(8'((fr * 71 + ln * 37 + i * 5 + g * 3 + f * 7 + p) ^ 8'h5A), 1'b1, 1'b1);
        px(8'(fr * 90 + ln * 29 + 3), 1'b0, 1'b1);
        px(8'(fr * 90 + ln * 29 + 4), 1'b0, 1'b1);
        // R8: saturating line length
        check("R8 line count", line_pix_count, (len > CMAX) ? CMAX : len);
      end
      px(8'hE0, 1'b0, 1'b0);
      px(8'hE1, 1'b0, 1'b0);
      // R3: in gated mode a line outside the frame still counts
      if (g != 0) begin
        for (int i = 0; i < 2; i++) px(8'(8'hC0 + i), 1'b1, 1'b0);
        px(8'hE2, 1'b0, 1'b0);
      end
    end
    repeat (4) @(negedge clk);
    check("R6 sof count", sof_seen, sof_exp);
    check("R2/R3/R4 byte count", got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      check("R5 byte value", got_q[i], exp_q[i]);
    // R5: data holds between strobes
    check("R5 hold", pix_data, exp_q[exp_q.size() - 1]);
  endtask

  initial begin
    for (int g = 0; g < 2; g++)
      for (int f = 0; f < 2; f++)
        for (int p = 0; p < 2; p++)
          run_cfg(g, f, p);
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule